// File: doc/BRIEF.md
# Cycle Counter with Tap Post-Scaler

This block keeps a free-running cycle count for a processor debug subsystem. From that count it derives two kinds of periodic strobe. The first kind comes from a selectable low-order bit of the count. Each flip of that bit, in either direction, is a tap. Taps pass through a reloadable 4-bit divide-down counter, and the result becomes either a PC-sample strobe or a cycle-count strobe. The second kind is a slower synchronization pulse, taken from one of three high-order bits and gated by an external enable.

Software programs the block through a small write port. One select value addresses the control word and the other addresses the counter value. The control word, the counter value and a PC-sample value are always visible on read outputs. The PC-sample value mirrors the executing instruction address. While the core is halted it reads all ones. Downstream trace logic consumes the single-cycle strobes. Packet formatting is not part of this block.

Top module: `cycle_tap_sampler`

## Requirements
- R1: With the enable (control bit 0) set and the core not halted, the counter advances by one each clock. It holds its value while the enable is clear or the core is halted.
- R2: The counter is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R3: A counter write (wr_sel = 1) loads wr_data in place of that cycle's increment. A bit change caused by such a write is not a tap.
- R4: Tap select (control bit 9) picks counter bit 6 when 0 and bit 10 when 1. Both rising and falling flips of the picked bit are taps.
- R5: The divide-down value sits in control bits 8:5 and the preset in bits 4:1. On a tap, a nonzero divide-down value decrements. A zero value fires an event and reloads the preset. A preset of 0 fires on every tap, and a preset of 1 fires on every second tap.
- R6: A fired event drives pc_sample_evt when control bit 12 is set, and cyc_evt never fires then. Otherwise it drives cyc_evt only if control bit 22 is set.
- R7: Sync select (control bits 11:10) encodes 0 = off, 1 = bit 24, 2 = bit 26, 3 = bit 28. sync_pulse fires on each flip of that bit, but only while the counter is advancing and sync_allow is high.
- R8: Control reads back the fields at bits 0, 4:1, 8:5, 9, 11:10, 12 and 22, with all other bits 0 except bit 25. After reset, control, counter and all strobes are 0.
- R9: With parameter NO_CYC = 1, control bit 0 always reads 0 and ignores writes, the counter never advances, and control bit 25 reads 1. With NO_CYC = 0, bit 25 reads 0.
- R10: pc_sample_val equals pc_in while the core runs and 0xFFFFFFFF while core_halted is high.
- R11: Each strobe lasts one cycle. It is registered on the same edge that moves the counter across the flip, so it is high exactly while the counter shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 counter value |
| wr_data | input | 32 | Write data |
| core_halted | input | 1 | Core is halted |
| sync_allow | input | 1 | External enable for sync pulses |
| pc_in | input | 32 | Address of the executing instruction |
| ctrl_rdata | output | 32 | Control word readback |
| cnt_rdata | output | 32 | Counter value |
| pc_sample_val | output | 32 | PC-sample readback |
| pc_sample_evt | output | 1 | PC-sample strobe |
| cyc_evt | output | 1 | Cycle-count strobe |
| sync_pulse | output | 1 | Synchronization strobe |

## Verification
The tap path is run from a known counter start over fixed windows. Three settings are used: preset 0 on bit 6, preset 1 on bit 6, and preset 0 on bit 10. The strobe count and the counter value at the last strobe separate the two tap bits, separate divide-by-one from divide-by-two, and pin the exact cycle of each strobe.

The same window is repeated with both event enables set and with neither set, which exposes any error in the routing priority. Sync is checked by starting just below bit 24, 26 or 28 under different selects. A start where only an unselected bit flips must give no pulse, and so must a start with sync_allow low.

Counter writes that move the tap bit, halts, disables and the wrap point round out the counting checks. A second instance built with the counter absent runs the same writes alongside.

// File: rtl/cts_pkg.sv
package cts_pkg;
    localparam int CNT_W = 32;
    localparam int PS_W  = 4;
    localparam int SEL_W = 2;

    localparam int EN_B       = 0;
    localparam int PRESET_LSB = 1;
    localparam int PS_LSB     = PRESET_LSB + PS_W;
    localparam int TAP_B      = PS_LSB + PS_W;
    localparam int SYNC_LSB   = TAP_B + 1;
    localparam int PCS_B      = SYNC_LSB + SEL_W;
    localparam int CYCEV_B    = 22;
    localparam int ABSENT_B   = 25;

    typedef struct packed {
        logic             cyc_evt_en;
        logic             pcs_en;
        logic [SEL_W-1:0] sync_sel;
        logic             tap_sel;
        logic [PS_W-1:0]  ps;
        logic [PS_W-1:0]  preset;
        logic             cnt_en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic             pcs_evt;
        logic             cyc_evt;
        logic             sync_pulse;
    } state_t;
endpackage

// File: rtl/cts_count_next.sv
module cts_count_next #(
    parameter int W = 32
) (
    input  logic [W-1:0] cnt_q,
    input  logic         en,
    input  logic         halted,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_d,
    output logic         inc
);
    always_comb begin
        inc = en & ~halted & ~wr;
        if (wr) begin
            cnt_d = wr_data;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end
endmodule

// File: rtl/cts_bit_flip.sv
module cts_bit_flip #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  cur,
    input  logic [W-1:0]  nxt,
    input  logic [IW-1:0] idx,
    output logic          flip
);
    assign flip = cur[idx] ^ nxt[idx];
endmodule

// File: rtl/cts_postscale.sv
module cts_postscale #(
    parameter int PW = 4
) (
    input  logic          hit,
    input  logic [PW-1:0] ps_q,
    input  logic [PW-1:0] preset,
    output logic [PW-1:0] ps_d,
    output logic          fire
);
    always_comb begin
        fire = hit && (ps_q == '0);
        if (!hit) begin
            ps_d = ps_q;
        end else if (ps_q == '0) begin
            ps_d = preset;
        end else begin
            ps_d = ps_q - PW'(1);
        end
    end
endmodule

// File: rtl/cycle_tap_sampler.sv
module cycle_tap_sampler
    import cts_pkg::*;
#(
    parameter bit NO_CYC    = 1'b0,
    parameter int TAP_LO    = 6,
    parameter int TAP_HI    = 10,
    parameter int SYNC_BASE = 24,
    parameter int SYNC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             core_halted,
    input  logic             sync_allow,
    input  logic [CNT_W-1:0] pc_in,
    output logic [CNT_W-1:0] ctrl_rdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic [CNT_W-1:0] pc_sample_val,
    output logic             pc_sample_evt,
    output logic             cyc_evt,
    output logic             sync_pulse
);
    localparam int IW = $clog2(CNT_W);

    state_t st_q, st_d;

    logic             wr_ctrl, wr_cnt, en_wr;
    logic [CNT_W-1:0] cnt_nx;
    logic             inc, tap_flip, sync_flip, fire;
    logic [PS_W-1:0]  ps_nx;
    logic [IW-1:0]    tap_idx, sync_idx;
    int               sync_pos;

    assign wr_ctrl = wr_en & ~wr_sel;
    assign wr_cnt  = wr_en &  wr_sel;

    generate
        if (NO_CYC) begin : g_absent
            assign en_wr = 1'b0;
        end else begin : g_present
            assign en_wr = wr_data[EN_B];
        end
    endgenerate

    always_comb begin
        tap_idx  = st_q.ctrl.tap_sel ? IW'(TAP_HI) : IW'(TAP_LO);
        sync_pos = SYNC_BASE;
        if (st_q.ctrl.sync_sel != '0) begin
            sync_pos = SYNC_BASE + SYNC_STEP * (int'(st_q.ctrl.sync_sel) - 1);
        end
        sync_idx = sync_pos[IW-1:0];
    end

    cts_count_next #(.W(CNT_W)) u_count (
        .cnt_q   (st_q.cnt),
        .en      (st_q.ctrl.cnt_en),
        .halted  (core_halted),
        .wr      (wr_cnt),
        .wr_data (wr_data),
        .cnt_d   (cnt_nx),
        .inc     (inc)
    );

    cts_bit_flip #(.W(CNT_W), .IW(IW)) u_tap_flip (
        .cur  (st_q.cnt),
        .nxt  (cnt_nx),
        .idx  (tap_idx),
        .flip (tap_flip)
    );

    cts_bit_flip #(.W(CNT_W), .IW(IW)) u_sync_flip (
        .cur  (st_q.cnt),
        .nxt  (cnt_nx),
        .idx  (sync_idx),
        .flip (sync_flip)
    );

    cts_postscale #(.PW(PS_W)) u_post (
        .hit    (inc & tap_flip),
        .ps_q   (st_q.ctrl.ps),
        .preset (st_q.ctrl.preset),
        .ps_d   (ps_nx),
        .fire   (fire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = cnt_nx;
        st_d.ctrl.ps = ps_nx;
        if (wr_ctrl) begin
            st_d.ctrl.cnt_en     = en_wr;
            st_d.ctrl.preset     = wr_data[PRESET_LSB +: PS_W];
            st_d.ctrl.ps         = wr_data[PS_LSB +: PS_W];
            st_d.ctrl.tap_sel    = wr_data[TAP_B];
            st_d.ctrl.sync_sel   = wr_data[SYNC_LSB +: SEL_W];
            st_d.ctrl.pcs_en     = wr_data[PCS_B];
            st_d.ctrl.cyc_evt_en = wr_data[CYCEV_B];
        end
        st_d.pcs_evt    = fire & st_q.ctrl.pcs_en;
        st_d.cyc_evt    = fire & ~st_q.ctrl.pcs_en & st_q.ctrl.cyc_evt_en;
        st_d.sync_pulse = inc & (st_q.ctrl.sync_sel != '0) & sync_allow & sync_flip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rdata                         = '0;
        ctrl_rdata[EN_B]                   = st_q.ctrl.cnt_en;
        ctrl_rdata[PRESET_LSB +: PS_W]     = st_q.ctrl.preset;
        ctrl_rdata[PS_LSB +: PS_W]         = st_q.ctrl.ps;
        ctrl_rdata[TAP_B]                  = st_q.ctrl.tap_sel;
        ctrl_rdata[SYNC_LSB +: SEL_W]      = st_q.ctrl.sync_sel;
        ctrl_rdata[PCS_B]                  = st_q.ctrl.pcs_en;
        ctrl_rdata[CYCEV_B]                = st_q.ctrl.cyc_evt_en;
        ctrl_rdata[ABSENT_B]               = NO_CYC;
    end

    assign cnt_rdata     = st_q.cnt;
    assign pc_sample_val = core_halted ? '1 : pc_in;
    assign pc_sample_evt = st_q.pcs_evt;
    assign cyc_evt       = st_q.cyc_evt;
    assign sync_pulse    = st_q.sync_pulse;
endmodule

// File: rtl/cts_checks.sv
module cts_checks #(
    parameter bit NO_CYC = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic        core_halted,
    input logic        sync_allow,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] cnt_rdata,
    input logic        pc_sample_evt,
    input logic        cyc_evt,
    input logic        sync_pulse
);
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[0] && !core_halted && !(wr_en && wr_sel))
        |=> cnt_rdata == ($past(cnt_rdata) + 32'd1));

    a_r1_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halted && !(wr_en && wr_sel)) |=> $stable(cnt_rdata));

    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> cnt_rdata == $past(wr_data));

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_sample_evt || cyc_evt) && !$past(wr_en && !wr_sel))
        |-> ctrl_rdata[8:5] == ctrl_rdata[4:1]);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_sample_evt, cyc_evt}));

    a_r7_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(sync_allow) && ($past(ctrl_rdata[11:10]) != 2'd0)));

    a_r9_absent_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[25] == NO_CYC) && (!NO_CYC || !ctrl_rdata[0]));

    a_r11_cyc_single: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_evt |=> !cyc_evt);

    a_r11_pcs_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sample_evt |=> !pc_sample_evt);
endmodule

bind cycle_tap_sampler cts_checks #(.NO_CYC(NO_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .core_halted   (core_halted),
    .sync_allow    (sync_allow),
    .ctrl_rdata    (ctrl_rdata),
    .cnt_rdata     (cnt_rdata),
    .pc_sample_evt (pc_sample_evt),
    .cyc_evt       (cyc_evt),
    .sync_pulse    (sync_pulse)
);

// File: tb/tb_cycle_tap_sampler.sv
module tb_cycle_tap_sampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        core_halted = 1'b0;
    logic        sync_allow = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] ctrl_rd, cnt_rd, pcs_val;
    logic        pcs_evt, cyc_ev, sync_p;
    logic [31:0] nc_ctrl, nc_cnt, nc_pcs;
    logic        nc_pe, nc_ce, nc_sp;

    int checks = 0;
    int fails = 0;
    int n_cyc = 0, n_pcs = 0, n_sync = 0, n_double = 0;
    logic [31:0] last_cyc = '0, last_pcs = '0, last_sync = '0;
    logic prev_cyc = 1'b0, prev_pcs = 1'b0;

    always #2 clk = ~clk;

    cycle_tap_sampler dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .core_halted(core_halted), .sync_allow(sync_allow), .pc_in(pc_in),
        .ctrl_rdata(ctrl_rd), .cnt_rdata(cnt_rd), .pc_sample_val(pcs_val),
        .pc_sample_evt(pcs_evt), .cyc_evt(cyc_ev), .sync_pulse(sync_p)
    );

    cycle_tap_sampler #(.NO_CYC(1'b1)) dut_nc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .core_halted(core_halted), .sync_allow(sync_allow), .pc_in(pc_in),
        .ctrl_rdata(nc_ctrl), .cnt_rdata(nc_cnt), .pc_sample_val(nc_pcs),
        .pc_sample_evt(nc_pe), .cyc_evt(nc_ce), .sync_pulse(nc_sp)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_ev)  begin n_cyc++;  last_cyc  = cnt_rd; end
            if (pcs_evt) begin n_pcs++;  last_pcs  = cnt_rd; end
            if (sync_p)  begin n_sync++; last_sync = cnt_rd; end
            if ((cyc_ev && prev_cyc) || (pcs_evt && prev_pcs)) n_double++;
            prev_cyc = cyc_ev;
            prev_pcs = pcs_evt;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    function automatic logic [31:0] cfg(input logic en, input logic [3:0] preset,
                                        input logic tap, input logic [1:0] sync,
                                        input logic pcs, input logic cyc);
        return {9'b0, cyc, 9'b0, pcs, sync, tap, 4'b0, preset, en};
    endfunction

    task automatic setup(input logic [31:0] c, input logic [31:0] start);
        wr(1'b0, 32'h0);
        wr(1'b1, start);
        wr(1'b0, c);
    endtask

    task automatic t_reset;
        check("R8 reset ctrl", ctrl_rd, 32'h0);
        check("R8 reset count", cnt_rd, 32'h0);
        check("R8 reset strobes", {29'b0, pcs_evt, cyc_ev, sync_p}, 32'h0);
    endtask

    task automatic t_count;
        wr(1'b1, 32'h12345678);
        step(5);
        check("R1 hold while disabled", cnt_rd, 32'h12345678);
        setup(cfg(1, 0, 0, 0, 0, 0), 32'd5);
        step(10);
        check("R1 advance", cnt_rd, 32'd15);
        core_halted = 1'b1;
        step(10);
        check("R1 hold while halted", cnt_rd, 32'd15);
        core_halted = 1'b0;
        step(1);
        check("R1 resume", cnt_rd, 32'd16);
        wr(1'b0, 32'h0);
        step(5);
        check("R1 disable", cnt_rd, 32'd17);
    endtask

    task automatic t_wrap_prio;
        setup(cfg(1, 0, 0, 0, 0, 0), 32'hFFFF_FFFE);
        step(2);
        check("R2 wrap", cnt_rd, 32'h0);
        wr(1'b1, 32'h100);
        check("R3 write beats increment", cnt_rd, 32'h100);
        step(1);
        check("R3 count after write", cnt_rd, 32'h101);
    endtask

    task automatic t_write_no_tap;
        int c0;
        setup(cfg(1, 0, 0, 0, 0, 1), 32'h30);
        c0 = n_cyc;
        wr(1'b1, 32'h40);
        step(3);
        check("R3 write flip is no tap", n_cyc - c0, 0);
    endtask

    task automatic t_tap(input string req, input logic [31:0] c, input int win,
                         input int exp_cyc, input int exp_pcs, input logic [31:0] exp_last);
        int c0, p0;
        setup(c, 32'h0);
        c0 = n_cyc; p0 = n_pcs;
        step(win);
        check({req, " cyc count"}, n_cyc - c0, exp_cyc);
        check({req, " pcs count"}, n_pcs - p0, exp_pcs);
        if (exp_cyc > 0) check({req, " last cyc at"}, last_cyc, exp_last);
        if (exp_pcs > 0) check({req, " last pcs at"}, last_pcs, exp_last);
    endtask

    task automatic t_preset1;
        int c0;
        setup(cfg(1, 1, 0, 0, 0, 1), 32'h0);
        c0 = n_cyc;
        step(100);
        check("R5 divider reloaded to 1", {28'b0, ctrl_rd[8:5]}, 32'd1);
        step(200);
        check("R5 preset 1 halves rate", n_cyc - c0, 2);
        check("R5 preset 1 last at", last_cyc, 32'd192);
        check("R5 divider after second tap", {28'b0, ctrl_rd[8:5]}, 32'd0);
    endtask

    task automatic t_sync(input string req, input logic [1:0] sel, input logic allow,
                          input logic [31:0] start, input int exp_n, input logic [31:0] exp_at);
        int s0;
        sync_allow = allow;
        setup(cfg(1, 0, 0, sel, 0, 0), start);
        s0 = n_sync;
        step(40);
        check({req, " pulses"}, n_sync - s0, exp_n);
        if (exp_n > 0) check({req, " pulse at"}, last_sync, exp_at);
        sync_allow = 1'b0;
    endtask

    task automatic t_ctrl_read;
        wr(1'b0, 32'hFFFF_FFFF);
        check("R8 ctrl layout", ctrl_rd, 32'h0040_1FFF);
        check("R9 absent ctrl", nc_ctrl, 32'h0240_1FFE);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'd7);
        wr(1'b0, cfg(1, 0, 0, 0, 0, 0));
        step(5);
        check("R9 absent never counts", nc_cnt, 32'd7);
        check("R1 present counts alongside", cnt_rd, 32'd12);
    endtask

    task automatic t_pc;
        pc_in = 32'hCAFE_0010;
        core_halted = 1'b0;
        #1;
        check("R10 running pc", pcs_val, 32'hCAFE_0010);
        core_halted = 1'b1;
        #1;
        check("R10 halted pc", pcs_val, 32'hFFFF_FFFF);
        core_halted = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_count();
        t_wrap_prio();
        t_write_no_tap();
        t_tap("R4 R5 bit6 preset0", cfg(1, 0, 0, 0, 0, 1), 300, 4, 0, 32'd256);
        t_preset1();
        t_tap("R4 bit10 preset0", cfg(1, 0, 1, 0, 0, 1), 2100, 2, 0, 32'd2048);
        t_tap("R6 pcs overrides", cfg(1, 0, 0, 0, 1, 1), 300, 0, 4, 32'd256);
        t_tap("R6 both off", cfg(1, 0, 0, 0, 0, 0), 300, 0, 0, 32'd0);
        t_sync("R7 sel1 bit24", 2'd1, 1'b1, 32'h00FF_FFF0, 1, 32'h0100_0000);
        t_sync("R7 sel2 ignores bit24", 2'd2, 1'b1, 32'h02FF_FFF0, 0, 32'h0);
        t_sync("R7 sel2 bit26", 2'd2, 1'b1, 32'h03FF_FFF0, 1, 32'h0400_0000);
        t_sync("R7 sel3 bit28", 2'd3, 1'b1, 32'h0FFF_FFF0, 1, 32'h1000_0000);
        t_sync("R7 allow low", 2'd1, 1'b0, 32'h00FF_FFF0, 0, 32'h0);
        t_sync("R7 sel0 off", 2'd0, 1'b1, 32'h00FF_FFF0, 0, 32'h0);
        t_ctrl_read();
        t_pc();
        check("R11 strobes single-cycle", n_double, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule